// File: doc/BRIEF.md
# T1 Framing Sync Validator

This block watches the framing-bit slots of a received T1 stream that an upstream framer has already aligned. For every framing slot it is told about, it decides whether that slot carries a checked framing bit and whether the received value matches the expected framing pattern. The stream can be a 12-frame superframe or a 24-frame extended superframe. From those per-bit verdicts it keeps a synchronization flag. The flag also takes account of a loss indication from the external framer.

While the flag is high, every framing-bit error adds one to a saturating error counter. The counter holds its value while the flag is low, and a clear strobe sets it back to zero. The block does not search for frame alignment. It relies on a strobe marking each framing slot and on a second strobe marking the first frame of each superframe.

Top module: `t1_sync_validator`

## Requirements
- R1: After a synchronous reset, `sync_ok` is 0 and `err_count` is 0.
- R2: In 12-frame mode with `fs_sel`=0, only the framing bits of odd frames 1,3,5,7,9,11 are checked, against the values 1,0,1,0,1,0 in that order. A wrong bit in an even frame does not change `err_count`.
- R3: In 12-frame mode with `fs_sel`=1, the even frames 2,4,6,8,10 are also checked, against 0,0,1,1,1. Frame 12 is never checked.
- R4: With `esf_mode`=1, only frames 4,8,12,16,20,24 are checked, against 0,0,1,0,1,1. Framing slots of all other frames are ignored.
- R5: When out of sync, `sync_ok` rises in the cycle after the last framing slot of the second consecutive superframe whose checked bits were all correct, provided `ext_loss` was low.
- R6: A superframe with any checked-bit error sets the clean-superframe count back to zero.
- R7: While in sync, `sync_ok` falls in the cycle after a checked bit whose error makes two errors among the last four checked bits, the current one included.
- R8: When `ext_loss` is sampled high, `sync_ok` is 0 from the next cycle on. No superframe that overlaps a high `ext_loss` counts toward regaining sync.
- R9: `err_count` rises by one for each checked-bit error that is sampled while `sync_ok` is 1. It is frozen while `sync_ok` is 0.
- R10: `err_count` stays at its all-ones value when further errors arrive.
- R11: `cnt_clear` sets `err_count` to 0 in the next cycle. If an error that counts is sampled in the same cycle, the result is 1.
- R12: A framing slot (`fbit_valid`=1) with `mf_first`=1 is frame 1. Each later slot advances the frame number, which wraps after frame 12 (or 24 in extended mode). Slots before the first `mf_first` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received line bit |
| fbit_valid | input | 1 | `rx_bit` is a framing-bit slot this cycle |
| mf_first | input | 1 | With `fbit_valid`, this slot belongs to frame 1 |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| fs_sel | input | 1 | 12-frame mode: also check even-frame framing bits |
| ext_loss | input | 1 | External framer reports loss of sync |
| cnt_clear | input | 1 | Clear the error counter |
| sync_ok | output | 1 | Registered synchronization flag |
| err_count | output | CNT_W | Registered saturating framing-error count |

## Verification
Two events can fall in the same cycle and compete for the same register. The counter clear can coincide with a counted framing error, and the external loss flag can coincide with a checked framing slot. The bench pulses `cnt_clear` exactly on the slot of a deliberately corrupted frame-7 bit and expects a count of 1, not 0 or the old value plus one. It also raises `ext_loss` while framing slots continue, and expects the flag to drop on the next cycle and stay low across two otherwise clean superframes. A behavioural model recomputes both outputs on every clock, so any difference in the order of these competing updates shows up on the cycle where it happens.

// File: rtl/t1sv_pkg.sv
package t1sv_pkg;
  localparam int SF_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int IDX_W      = $clog2(ESF_FRAMES);

  typedef logic [IDX_W-1:0] idx_t;

  // Expected framing values, bit k belongs to the k-th checked slot.
  localparam logic [5:0] FT_PAT  = 6'b010101;
  localparam logic [5:0] FS_PAT  = 6'b011100;
  localparam logic [5:0] ESF_PAT = 6'b110100;
  localparam logic [2:0] FS_SKIP = 3'd5;
endpackage

// File: rtl/t1sv_frame_pos.sv
module t1sv_frame_pos
  import t1sv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fbit_valid,
  input  logic mf_first,
  input  logic esf_mode,
  output idx_t cur_idx,
  output logic cur_valid,
  output logic cur_first,
  output logic cur_last
);
  logic aligned_q;
  idx_t idx_q;
  idx_t last_idx;

  always_comb begin
    last_idx  = esf_mode ? idx_t'(ESF_FRAMES - 1) : idx_t'(SF_FRAMES - 1);
    if (mf_first || idx_q == last_idx) cur_idx = '0;
    else                               cur_idx = idx_q + idx_t'(1);
    cur_valid = fbit_valid & (mf_first | aligned_q);
    cur_first = cur_valid & (cur_idx == '0);
    cur_last  = cur_valid & (cur_idx == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned_q <= 1'b0;
      idx_q     <= '0;
    end else if (cur_valid) begin
      aligned_q <= 1'b1;
      idx_q     <= cur_idx;
    end
  end
endmodule

// File: rtl/t1sv_frame_check.sv
module t1sv_frame_check
  import t1sv_pkg::*;
(
  input  idx_t cur_idx,
  input  logic cur_valid,
  input  logic esf_mode,
  input  logic fs_sel,
  input  logic rx_bit,
  output logic chk_en,
  output logic bit_err
);
  logic [2:0] k_sf;
  logic [2:0] k_esf;
  logic       pos_chk;
  logic       exp_bit;

  always_comb begin
    k_sf    = cur_idx[3:1];
    k_esf   = cur_idx[4:2];
    pos_chk = 1'b0;
    exp_bit = 1'b0;
    if (esf_mode) begin
      pos_chk = (cur_idx[1:0] == 2'b11);
      exp_bit = ESF_PAT[k_esf];
    end else if (!cur_idx[0]) begin
      pos_chk = 1'b1;
      exp_bit = FT_PAT[k_sf];
    end else begin
      pos_chk = fs_sel && (k_sf != FS_SKIP);
      exp_bit = FS_PAT[k_sf];
    end
    chk_en  = cur_valid & pos_chk;
    bit_err = chk_en & (rx_bit ^ exp_bit);
  end
endmodule

// File: rtl/t1sv_sync_fsm.sv
module t1sv_sync_fsm #(
  parameter int SYNC_SF = 2,
  parameter int WIN     = 4,
  parameter int LOSS_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cur_valid,
  input  logic cur_first,
  input  logic cur_last,
  input  logic chk_en,
  input  logic bit_err,
  input  logic ext_loss,
  output logic sync_q
);
  localparam int GW = $clog2(SYNC_SF + 1);

  logic [WIN-1:0] hist_q;
  logic [GW-1:0]  good_q;
  logic           sf_bad_q;
  logic           bad_total;
  logic           trip;
  int             win_ones;

  always_comb begin
    bad_total = (cur_first ? 1'b0 : sf_bad_q) | bit_err;
    win_ones  = int'(bit_err);
    for (int i = 0; i < WIN - 1; i++) win_ones += int'(hist_q[i]);
    trip = bit_err && (win_ones >= LOSS_N);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      hist_q   <= '0;
      good_q   <= '0;
      sf_bad_q <= 1'b0;
    end else if (ext_loss) begin
      sync_q   <= 1'b0;
      hist_q   <= '0;
      good_q   <= '0;
      sf_bad_q <= 1'b1;
    end else begin
      if (cur_valid) sf_bad_q <= bad_total;
      if (sync_q) begin
        if (chk_en) begin
          if (trip) begin
            sync_q <= 1'b0;
            hist_q <= '0;
            good_q <= '0;
          end else begin
            hist_q <= {hist_q[WIN-2:0], bit_err};
          end
        end
      end else begin
        hist_q <= '0;
        if (cur_last) begin
          if (bad_total) begin
            good_q <= '0;
          end else if (good_q == GW'(SYNC_SF - 1)) begin
            sync_q <= 1'b1;
            good_q <= '0;
          end else begin
            good_q <= good_q + GW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/t1sv_err_cnt.sv
module t1sv_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             err_pulse,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic inc;
  assign inc = count_en & err_pulse;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (clr)                  cnt_q <= inc ? CNT_W'(1) : '0;
    else if (inc && cnt_q != MAXV) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/t1_sync_validator.sv
module t1_sync_validator
  import t1sv_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SYNC_SF = 2,
  parameter int WIN     = 4,
  parameter int LOSS_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             fbit_valid,
  input  logic             mf_first,
  input  logic             esf_mode,
  input  logic             fs_sel,
  input  logic             ext_loss,
  input  logic             cnt_clear,
  output logic             sync_ok,
  output logic [CNT_W-1:0] err_count
);
  idx_t cur_idx;
  logic cur_valid, cur_first, cur_last;
  logic chk_en, bit_err;

  t1sv_frame_pos u_pos (
    .clk(clk), .rst(rst), .fbit_valid(fbit_valid), .mf_first(mf_first),
    .esf_mode(esf_mode), .cur_idx(cur_idx), .cur_valid(cur_valid),
    .cur_first(cur_first), .cur_last(cur_last)
  );

  t1sv_frame_check u_chk_bits (
    .cur_idx(cur_idx), .cur_valid(cur_valid), .esf_mode(esf_mode),
    .fs_sel(fs_sel), .rx_bit(rx_bit), .chk_en(chk_en), .bit_err(bit_err)
  );

  t1sv_sync_fsm #(.SYNC_SF(SYNC_SF), .WIN(WIN), .LOSS_N(LOSS_N)) u_fsm (
    .clk(clk), .rst(rst), .cur_valid(cur_valid), .cur_first(cur_first),
    .cur_last(cur_last), .chk_en(chk_en), .bit_err(bit_err),
    .ext_loss(ext_loss), .sync_q(sync_ok)
  );

  t1sv_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .count_en(sync_ok), .err_pulse(bit_err),
    .clr(cnt_clear), .cnt_q(err_count)
  );
endmodule

// File: rtl/t1sv_checker.sv
module t1sv_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_loss,
  input logic             cnt_clear,
  input logic             sync_ok,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!sync_ok && err_count == '0));

  a_r8_ext_drop: assert property (@(posedge clk) disable iff (rst)
    ext_loss |=> !sync_ok);

  a_r5_gain_needs_no_ext: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_ok) |-> !$past(ext_loss));

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (!sync_ok && !cnt_clear) |=> $stable(err_count));

  a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_clear |=> (err_count == $past(err_count) ||
                    err_count == $past(err_count) + CNT_W'(1)));

  a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
    (err_count == MAXV && !cnt_clear) |=> err_count == MAXV);

  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> err_count <= CNT_W'(1));
endmodule

bind t1_sync_validator t1sv_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst), .ext_loss(ext_loss), .cnt_clear(cnt_clear),
  .sync_ok(sync_ok), .err_count(err_count)
);

// File: tb/sim_t1_sync_validator.sv
module sim_t1_sync_validator;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst, rx_bit, fbit_valid, mf_first, esf_mode, fs_sel, ext_loss, cnt_clear;
  logic             sync_ok;
  logic [CNT_W-1:0] err_count;

  int errs = 0, checks = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_sync_validator #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .fbit_valid(fbit_valid),
    .mf_first(mf_first), .esf_mode(esf_mode), .fs_sel(fs_sel),
    .ext_loss(ext_loss), .cnt_clear(cnt_clear), .sync_ok(sync_ok),
    .err_count(err_count)
  );

  // ---------------- reference model ----------------
  int ft_v[6]  = '{1,0,1,0,1,0};
  int fs_v[6]  = '{0,0,1,1,1,0};
  int esf_v[6] = '{0,0,1,0,1,1};

  function automatic int exp_of(input int esf, input int n);
    if (esf != 0) return (n % 4 == 0) ? esf_v[n/4-1] : (n & 1);
    return (n % 2 == 1) ? ft_v[(n-1)/2] : fs_v[n/2-1];
  endfunction

  function automatic bit checked(input int esf, input int fsel, input int n);
    if (esf != 0) return (n % 4 == 0);
    if (n % 2 == 1) return 1'b1;
    return (fsel != 0) && (n != 12);
  endfunction

  int m_frame, m_sync, m_cnt, m_good, m_sf_bad;
  bit m_aligned;
  int hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_frame = 0; m_sync = 0; m_cnt = 0; m_good = 0; m_sf_bad = 0;
      m_aligned = 0; hist.delete();
    end else begin
      automatic int nfr = esf_mode ? 24 : 12;
      automatic bit valid = fbit_valid && (mf_first || m_aligned);
      automatic int n = mf_first ? 1 : ((m_frame >= nfr) ? 1 : m_frame + 1);
      automatic bit chk = valid && checked(esf_mode, fs_sel, n);
      automatic bit err = chk && (int'(rx_bit) != exp_of(esf_mode, n));
      automatic int old_sync = m_sync;
      automatic bit bad = 0;
      if (valid) begin m_aligned = 1; m_frame = n; end
      if (cnt_clear) m_cnt = (old_sync != 0 && err) ? 1 : 0;
      else if (old_sync != 0 && err && m_cnt < CMAX) m_cnt++;
      if (valid) begin
        bad = ((n == 1) ? 0 : m_sf_bad) || err;
        m_sf_bad = bad;
      end
      if (ext_loss) begin
        m_sync = 0; m_good = 0; m_sf_bad = 1; hist.delete();
      end else if (old_sync != 0) begin
        if (chk) begin
          automatic int ones = 0;
          hist.push_back(int'(err));
          if (hist.size() > 4) void'(hist.pop_front());
          foreach (hist[i]) ones += hist[i];
          if (ones >= 2) begin m_sync = 0; m_good = 0; hist.delete(); end
        end
      end else begin
        hist.delete();
        if (valid && n == nfr) begin
          if (bad) m_good = 0;
          else if (m_good + 1 >= 2) begin m_sync = 1; m_good = 0; end
          else m_good++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(sync_ok) != m_sync || int'(err_count) != m_cnt) begin
        errs++;
        $display("FAIL %s model compare: sync=%0d cnt=%0d expected sync=%0d cnt=%0d",
                 cur_req, sync_ok, err_count, m_sync, m_cnt);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fbit(input logic b, input logic first, input logic clr);
    @(posedge clk); #1;
    fbit_valid = 1'b1; rx_bit = b; mf_first = first; cnt_clear = clr;
    @(posedge clk); #1;
    fbit_valid = 1'b0; mf_first = 1'b0; cnt_clear = 1'b0; rx_bit = ~b;
  endtask

  task automatic superframe(input int flips, input int clr_frame);
    automatic int nfr = esf_mode ? 24 : 12;
    for (int n = 1; n <= nfr; n++) begin
      automatic logic b = logic'(exp_of(esf_mode, n)) ^ logic'((flips >> (n-1)) & 1);
      fbit(b, n == 1, n == clr_frame);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic esf);
    @(posedge clk); #1;
    rst = 1'b1; esf_mode = esf; fs_sel = 1'b0; ext_loss = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; rx_bit = 1'b0; fbit_valid = 1'b0; mf_first = 1'b0;
    esf_mode = 1'b0; fs_sel = 1'b0; ext_loss = 1'b0; cnt_clear = 1'b0;
    do_reset(1'b0);
    cur_req = "R1";
    check("R1", sync_ok, 0, "sync after reset");
    check("R1", err_count, 0, "count after reset");

    cur_req = "R12";
    for (int i = 0; i < 5; i++) fbit(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R12", sync_ok, 0, "no sync before frame-1 strobe");

    cur_req = "R5";
    superframe(0, 0);
    check("R5", sync_ok, 0, "one clean superframe is not enough");
    superframe(0, 0);
    check("R5", sync_ok, 1, "sync after two clean superframes");

    cur_req = "R2";
    superframe(32'h0AAA, 0);
    check("R2", err_count, 0, "even-frame errors ignored with fs_sel=0");
    check("R2", sync_ok, 1, "still in sync");

    cur_req = "R9";
    superframe(32'h0101, 0);
    check("R9", err_count, 2, "errors 4 checked bits apart counted");
    check("R7", sync_ok, 1, "spaced errors keep sync");
    superframe(0, 0);

    cur_req = "R7";
    superframe(32'h0011, 0);
    check("R7", sync_ok, 0, "two errors in four checked bits lose sync");
    check("R9", err_count, 4, "both errors counted");

    cur_req = "R6";
    superframe(32'h0004, 0);
    check("R9", err_count, 4, "count frozen out of sync");
    superframe(0, 0);
    check("R6", sync_ok, 0, "bad superframe restarts clean count");
    superframe(0, 0);
    check("R6", sync_ok, 1, "sync after two clean after a bad one");

    cur_req = "R3";
    fs_sel = 1'b1;
    superframe(32'h0800, 0);
    check("R3", err_count, 4, "frame 12 never checked");
    superframe(32'h0008, 0);
    check("R3", err_count, 5, "frame 4 checked with fs_sel=1");

    cur_req = "R11";
    superframe(32'h0040, 7);
    check("R11", err_count, 1, "clear with same-cycle error gives 1");
    @(posedge clk); #1 cnt_clear = 1'b1;
    @(posedge clk); #1 cnt_clear = 1'b0;
    @(negedge clk);
    check("R11", err_count, 0, "plain clear");

    cur_req = "R8";
    @(posedge clk); #1 ext_loss = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", sync_ok, 0, "external loss drops sync next cycle");
    superframe(0, 0);
    superframe(0, 0);
    check("R8", sync_ok, 0, "no regain while external loss high");
    #1 ext_loss = 1'b0;
    superframe(0, 0);
    superframe(0, 0);
    check("R8", sync_ok, 1, "regain after external loss clears");

    cur_req = "R4";
    do_reset(1'b1);
    superframe(0, 0);
    superframe(0, 0);
    check("R4", sync_ok, 1, "extended mode sync");
    superframe(32'hFFFFFF & ~32'h888888, 0);
    check("R4", err_count, 0, "non-pattern frames ignored");
    superframe(32'h000080, 0);
    check("R4", err_count, 1, "frame 8 checked");

    cur_req = "R10";
    begin
      automatic int g = 0;
      for (int m = 0; m < 47; m++) begin
        automatic int mask = 0;
        for (int n = 4; n <= 24; n += 4) begin
          if (g % 4 == 0) mask |= (1 << (n-1));
          g++;
        end
        superframe(mask, 0);
      end
    end
    check("R10", err_count, CMAX, "counter saturates");
    check("R10", sync_ok, 1, "spaced errors keep sync during saturation");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule